// File: doc/BRIEF.md
# Watchdog Timer with Safe Frequency Fallback

This block supervises system software with a coarse-grained countdown. A prescaler divides the system clock into ticks. With the default setting one tick is 293 ms at a 100 MHz clock, and the length is a parameter so that a simulation can use a short tick. A tick counter measures the time since the last service event. Software services the watchdog with a kick pulse, or by writing a new timeout value. If the programmed number of ticks passes without service, the block enters an alarm state.

In the alarm state the block sets a status flag and issues a system reset request pulse of fixed length. It also replaces the normal frequency-select code on its output with a separately programmed safe code, so that a downstream clock generator can fall back to a known-good operating point. The alarm, and with it the safe code, stays in place until software clears the status or turns the watchdog off. Retuning the clock generator is the job of the consumer of the selected code.

Top module: `wdog_safefreq`

## Requirements
- R1: After reset the alarm status and the reset request are low, the output code equals `norm_code`, and the internal timeout register holds 16 ticks.
- R2: With `wd_enable` high and a timeout of N > 0 ticks, the alarm status rises exactly N×TICK_CYCLES clock edges after counting starts. Counting starts at the first edge with `wd_enable` high, or at the edge that samples a reload.
- R3: A `kick` sampled at an edge reloads the count to zero. It takes priority over an expiry falling on the same edge, so no alarm is raised on that edge.
- R4: A `tmo_we` pulse stores `tmo_wdata` as the new timeout in ticks and reloads the count, exactly as a kick does.
- R5: A timeout value of zero never raises the alarm.
- R6: `rst_req` goes high on the edge where the alarm status rises, and stays high for exactly RST_CYCLES clock cycles.
- R7: `freq_sel` equals `safe_code` while the alarm status is high, and `norm_code` otherwise.
- R8: Once raised, the alarm status stays high until `status_clr` is sampled. The clear reloads the count, so the next alarm follows a full timeout.
- R9: While `wd_enable` is low, counting stops and the prescaler phase resets. From the next edge on, the alarm status and `rst_req` are low.
- R10: While the alarm status is high, no ticks are counted and no further reset pulse is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wd_enable | input | 1 | Watchdog on (1) or off (0) |
| tmo_wdata | input | 8 | New timeout value, in ticks |
| tmo_we | input | 1 | Write strobe for the timeout register; also reloads the count |
| safe_code | input | 5 | Frequency-select code to apply during an alarm |
| norm_code | input | 5 | Frequency-select code for normal operation |
| kick | input | 1 | Service pulse that reloads the count |
| status_clr | input | 1 | Clears the alarm status and reloads the count |
| alarm_status | output | 1 | High while in the alarm state |
| rst_req | output | 1 | System reset request pulse |
| freq_sel | output | 5 | Currently selected frequency-select code |

## Verification
A service event and the final tick of the timeout can fall on the same clock edge. The bench provokes this by placing a kick, and separately a timeout write, on exactly the edge at which the count would expire. It judges the result by requiring that the alarm stays low and that a full fresh timeout then passes before the alarm rises. A second coincidence is a disable arriving while the reset pulse is still running. The bench requires that both the pulse and the alarm drop on the next edge.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic {
    WD_WATCH = 1'b0,
    WD_ALARM = 1'b1
  } wd_state_e;
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int TICK_CYCLES = 29_300_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int CW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

  logic [CW-1:0] phase_q;

  assign tick = run && !restart && (phase_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !run || restart) phase_q <= '0;
    else if (phase_q == LAST)      phase_q <= '0;
    else                           phase_q <= phase_q + 1'b1;
  end

  // R9: a stopped prescaler starts from phase zero
  assert_stop_phase_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> phase_q == '0);
endmodule

// File: rtl/wdog_tick_counter.sv
module wdog_tick_counter #(
  parameter int TMO_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic             tick,
  input  logic [TMO_W-1:0] limit,
  output logic             expire
);
  logic [TMO_W-1:0] elapsed_q;

  assign expire = run && !restart && tick && (limit != '0) &&
                  (elapsed_q == limit - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n || !run || restart) elapsed_q <= '0;
    else if (expire)               elapsed_q <= '0;
    else if (tick)                 elapsed_q <= elapsed_q + 1'b1;
  end

  // R3: any reload leaves the elapsed count at zero
  assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> elapsed_q == '0);
endmodule

// File: rtl/wdog_alarm.sv
module wdog_alarm
  import wdog_pkg::*;
#(
  parameter int RST_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic expire,
  input  logic status_clr,
  output logic alarm_o,
  output logic rst_req_o
);
  localparam int PW = $clog2(RST_CYCLES + 1);

  wd_state_e     state_q;
  logic [PW-1:0] pulse_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      state_q <= WD_WATCH;
      pulse_q <= '0;
    end else begin
      if (status_clr)  state_q <= WD_WATCH;
      else if (expire) state_q <= WD_ALARM;
      if (expire && !status_clr && state_q == WD_WATCH) pulse_q <= PW'(RST_CYCLES);
      else if (pulse_q != '0)                           pulse_q <= pulse_q - 1'b1;
    end
  end

  assign alarm_o   = (state_q == WD_ALARM);
  assign rst_req_o = (pulse_q != '0);

  // R8: alarm persists until cleared
  assert_alarm_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_o && enable && !status_clr |=> alarm_o);
  // R8: clear drops the alarm
  assert_alarm_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    status_clr |=> !alarm_o);
  // R9: disable drops alarm and reset request
  assert_disable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !alarm_o && !rst_req_o);
  // R6: a reset pulse only starts together with a new alarm
  assert_pulse_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req_o) |-> $rose(alarm_o));
endmodule

// File: rtl/wdog_safefreq.sv
module wdog_safefreq #(
  parameter int TICK_CYCLES = 29_300_000,
  parameter int RST_CYCLES  = 16,
  parameter int TMO_W       = 8,
  parameter int CODE_W      = 5,
  parameter int TMO_RESET   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wd_enable,
  input  logic [TMO_W-1:0]  tmo_wdata,
  input  logic              tmo_we,
  input  logic [CODE_W-1:0] safe_code,
  input  logic [CODE_W-1:0] norm_code,
  input  logic              kick,
  input  logic              status_clr,
  output logic              alarm_status,
  output logic              rst_req,
  output logic [CODE_W-1:0] freq_sel
);
  localparam logic [TMO_W-1:0] TMO_INIT = TMO_W'(TMO_RESET);

  logic [TMO_W-1:0] tmo_q;
  logic run, reload, tick_w, expire_w;

  always_ff @(posedge clk) begin
    if (!rst_n)      tmo_q <= TMO_INIT;
    else if (tmo_we) tmo_q <= tmo_wdata;
  end

  assign run    = wd_enable && !alarm_status;
  assign reload = kick || tmo_we || status_clr;

  wdog_prescaler #(.TICK_CYCLES(TICK_CYCLES)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(reload), .tick(tick_w)
  );

  wdog_tick_counter #(.TMO_W(TMO_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(reload),
    .tick(tick_w), .limit(tmo_q), .expire(expire_w)
  );

  wdog_alarm #(.RST_CYCLES(RST_CYCLES)) u_alm (
    .clk(clk), .rst_n(rst_n), .enable(wd_enable), .expire(expire_w),
    .status_clr(status_clr), .alarm_o(alarm_status), .rst_req_o(rst_req)
  );

  assign freq_sel = alarm_status ? safe_code : norm_code;

  // R10: no ticks are counted during an alarm
  assert_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_status |-> !tick_w);
  // R5: a zero timeout cannot raise the alarm
  assert_zero_tmo_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_q == '0) && !alarm_status |=> !alarm_status);
endmodule

// File: tb/sim_wdog_safefreq.sv
module sim_wdog_safefreq;
  localparam int CLK_PERIOD = 10;
  localparam int TICK = 8;
  localparam int RSTC = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wd_enable = 1'b0;
  logic [7:0] tmo_wdata = '0;
  logic tmo_we = 1'b0;
  logic [4:0] safe_code = 5'h13;
  logic [4:0] norm_code = 5'h04;
  logic kick = 1'b0;
  logic status_clr = 1'b0;
  logic alarm_status, rst_req;
  logic [4:0] freq_sel;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_safefreq #(.TICK_CYCLES(TICK), .RST_CYCLES(RSTC)) u0 (
    .clk(clk), .rst_n(rst_n), .wd_enable(wd_enable), .tmo_wdata(tmo_wdata),
    .tmo_we(tmo_we), .safe_code(safe_code), .norm_code(norm_code), .kick(kick),
    .status_clr(status_clr), .alarm_status(alarm_status), .rst_req(rst_req),
    .freq_sel(freq_sel)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_kick();
    kick = 1'b1; @(negedge clk); kick = 1'b0;
  endtask

  task automatic pulse_clr();
    status_clr = 1'b1; @(negedge clk); status_clr = 1'b0;
  endtask

  task automatic write_tmo(input int v);
    tmo_wdata = 8'(v); tmo_we = 1'b1; @(negedge clk); tmo_we = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 alarm", alarm_status, 0);
    chk("R1 rst_req", rst_req, 0);
    chk("R1 freq_sel", freq_sel, norm_code);
  endtask

  // default timeout of 16 ticks, reset pulse, safe code, no retrigger
  task automatic t_default_expiry();
    int highs = 0;
    wd_enable = 1'b1;
    wait_n(16*TICK - 1);
    chk("R1/R2 before expiry", alarm_status, 0);
    chk("R7 normal code", freq_sel, norm_code);
    wait_n(1);
    chk("R2 alarm at expiry", alarm_status, 1);
    chk("R7 safe code", freq_sel, safe_code);
    for (int i = 0; i < 40; i++) begin
      if (rst_req) highs++;
      @(negedge clk);
    end
    chk("R6 pulse length", highs, RSTC);
    chk("R10 no second pulse", rst_req, 0);
    chk("R8 alarm held", alarm_status, 1);
  endtask

  task automatic t_clear();
    pulse_clr();
    chk("R8 cleared", alarm_status, 0);
    chk("R7 code back", freq_sel, norm_code);
    wait_n(16*TICK - 1);
    chk("R8 restart before", alarm_status, 0);
    wait_n(1);
    chk("R8 restart expiry", alarm_status, 1);
    pulse_clr();
  endtask

  // service on the very edge of expiry
  task automatic t_kick_coincident();
    write_tmo(3);
    wait_n(3*TICK - 1);
    chk("R4 before new timeout", alarm_status, 0);
    pulse_kick();
    chk("R3 kick beats expiry", alarm_status, 0);
    wait_n(3*TICK - 1);
    chk("R3 full timeout after kick", alarm_status, 0);
    tmo_wdata = 8'd2; tmo_we = 1'b1; @(negedge clk); tmo_we = 1'b0;
    chk("R4 write beats expiry", alarm_status, 0);
    wait_n(2*TICK - 1);
    chk("R4 new value before", alarm_status, 0);
    wait_n(1);
    chk("R4 new value expiry", alarm_status, 1);
    pulse_clr();
  endtask

  task automatic t_zero();
    write_tmo(0);
    wait_n(300*TICK/8);
    chk("R5 zero never expires", alarm_status, 0);
    chk("R5 no reset request", rst_req, 0);
  endtask

  task automatic t_disable();
    safe_code = 5'h1E; norm_code = 5'h09;
    write_tmo(2);
    wait_n(2*TICK);
    chk("R7 other safe code", freq_sel, 5'h1E);
    chk("R6 pulse running", rst_req, 1);
    wd_enable = 1'b0; @(negedge clk);
    chk("R9 alarm off", alarm_status, 0);
    chk("R9 pulse cut", rst_req, 0);
    chk("R7 other normal code", freq_sel, 5'h09);
    wd_enable = 1'b1; wait_n(TICK + 3);
    wd_enable = 1'b0; wait_n(4);
    wd_enable = 1'b1;
    wait_n(2*TICK - 1);
    chk("R9 fresh count before", alarm_status, 0);
    wait_n(1);
    chk("R9 fresh count expiry", alarm_status, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_default_expiry();
    t_clear();
    t_kick_coincident();
    t_zero();
    t_disable();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule